// File: doc/BRIEF.md
# Disk Command Completion Timer

This block tracks how long a multi-drive disk controller needs to complete each command. It holds the current head position (cylinder) of each attached drive unit. Each accepted command loads a microsecond down-counter. The delay loaded depends on the operation class and, for head-moving and data-transfer operations, on how many cylinders lie between the unit's stored position and the requested one. A free-running microsecond tick paces the counter. When the last microsecond has elapsed, the block drops its busy flag and emits a single-cycle completion strobe.

Only one completion can be outstanding. A new command issued before the previous one finishes discards the old countdown and starts over. Two auxiliary clear codes and a dedicated cancel input abandon the pending completion so that no strobe occurs. The surrounding controller uses the strobe to post its completion status and interrupt. Data movement and status reporting sit outside this block.

Top module: `disk_cmd_timer`

## Requirements
- R1: After synchronous reset, `busy` and `done` are 0 and every unit's stored cylinder is 0.
- R2: Opcode 4'h1 (seek) has a delay of 700 µs plus 100 µs per cylinder of distance between the unit's stored cylinder and `cmd_cyl`. At acceptance it writes `cmd_cyl` into that unit's stored cylinder.
- R3: Opcode 4'h2 (return to cylinder zero) has a delay of 6000 µs and sets that unit's stored cylinder to 0.
- R4: Opcodes 4'h3 (read) and 4'h4 (write) have a delay of 8000 µs plus 100 µs per cylinder of distance, with a distance of 0 charged as 1. They leave the stored cylinder unchanged.
- R5: Opcode 4'h5 (unit status query) takes 200 µs, 4'h6 (drive parameter setup) takes 1250 µs, and 4'h7 (interrupt status query) takes 142 µs.
- R6: Every opcode other than 4'h1–4'h7, 4'hE and 4'hF takes 140 µs.
- R7: For a delay of N µs, `done` is high for exactly one cycle. That cycle follows the clock edge that samples the N-th `tick_us` after the accepting edge. `busy` is high from the cycle after acceptance until that same edge, and low while `done` is high. Ticks sampled while idle have no effect.
- R8: An asserted `cancel`, or an accepted opcode 4'hE or 4'hF, clears `busy` on the next cycle and prevents any `done` for the pending command. `cancel` takes priority over a command in the same cycle, and the command is then discarded.
- R9: A command accepted while `busy` restarts the countdown with its own delay. Only the new command produces a `done`.
- R10: Each of the four units keeps its own stored cylinder. The unit is selected by `cmd_unit`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Command presented this cycle |
| cmd_code | input | 4 | Operation code |
| cmd_unit | input | 2 | Drive unit number |
| cmd_cyl | input | 16 | Target cylinder |
| tick_us | input | 1 | One-cycle pulse per elapsed microsecond |
| cancel | input | 1 | Abandon any pending completion |
| busy | output | 1 | Countdown in progress |
| done | output | 1 | One-cycle completion strobe |

## Verification
The hardest behaviour to reach from the ports is the stored cylinder. It is never output directly and shows only as the length of a later seek or transfer. The stimulus therefore chains commands on the same unit, so that each measured delay proves where the previous command left the head. Examples are a write followed by a seek that must start from the pre-write position, a return-to-zero followed by a zero-distance seek, and a seek on one unit after activity on another. Cancellation and restart are reached by interrupting a long setup command partway through its countdown.

// File: rtl/ct_pkg.sv
package ct_pkg;

  typedef enum logic [3:0] {
    OP_MISC      = 4'h0,
    OP_SEEK      = 4'h1,
    OP_HOME      = 4'h2,
    OP_RDATA     = 4'h3,
    OP_WDATA     = 4'h4,
    OP_UNIT_STAT = 4'h5,
    OP_SETUP     = 4'h6,
    OP_INT_STAT  = 4'h7,
    OP_CLR_DONE  = 4'hE,
    OP_CLR_SVC   = 4'hF
  } op_e;

  function automatic logic op_is_aux(input logic [3:0] code);
    return (code == OP_CLR_DONE) || (code == OP_CLR_SVC);
  endfunction

endpackage

// File: rtl/ct_cyl_bank.sv
module ct_cyl_bank #(
  parameter int UNITS  = 4,
  parameter int UNIT_W = 2,
  parameter int CYL_W  = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   we,
  input  logic [UNIT_W-1:0]      waddr,
  input  logic [CYL_W-1:0]       wdata,
  input  logic [UNIT_W-1:0]      raddr,
  output logic [CYL_W-1:0]       rdata,
  output logic [UNITS*CYL_W-1:0] all_q
);

  logic [CYL_W-1:0] pos_q [UNITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int u = 0; u < UNITS; u++) pos_q[u] <= '0;
    end else if (we) begin
      pos_q[waddr] <= wdata;
    end
  end

  assign rdata = pos_q[raddr];

  for (genvar g = 0; g < UNITS; g++) begin : g_flat
    assign all_q[g*CYL_W +: CYL_W] = pos_q[g];
  end

endmodule

// File: rtl/ct_delay_calc.sv
module ct_delay_calc
  import ct_pkg::*;
#(
  parameter int CYL_W        = 16,
  parameter int CNT_W        = 24,
  parameter int SEEK_BASE_US = 700,
  parameter int STEP_US      = 100,
  parameter int HOME_US      = 6000,
  parameter int XFER_BASE_US = 8000,
  parameter int UNIT_STAT_US = 200,
  parameter int SETUP_US     = 1250,
  parameter int INT_STAT_US  = 142,
  parameter int MISC_US      = 140
) (
  input  logic [3:0]       op,
  input  logic [CYL_W-1:0] cur_cyl,
  input  logic [CYL_W-1:0] tgt_cyl,
  output logic [CNT_W-1:0] delay,
  output logic             cyl_we,
  output logic [CYL_W-1:0] cyl_new
);

  logic [CYL_W-1:0] span;
  logic [CYL_W-1:0] span_xfer;
  logic [CNT_W-1:0] travel;
  logic [CNT_W-1:0] travel_xfer;

  always_comb begin
    span        = (tgt_cyl >= cur_cyl) ? (tgt_cyl - cur_cyl) : (cur_cyl - tgt_cyl);
    span_xfer   = (span == '0) ? CYL_W'(1) : span;
    travel      = CNT_W'(span) * CNT_W'(STEP_US);
    travel_xfer = CNT_W'(span_xfer) * CNT_W'(STEP_US);
  end

  always_comb begin
    cyl_we  = 1'b0;
    cyl_new = tgt_cyl;
    case (op)
      OP_SEEK: begin
        delay   = CNT_W'(SEEK_BASE_US) + travel;
        cyl_we  = 1'b1;
      end
      OP_HOME: begin
        delay   = CNT_W'(HOME_US);
        cyl_we  = 1'b1;
        cyl_new = '0;
      end
      OP_RDATA, OP_WDATA: delay = CNT_W'(XFER_BASE_US) + travel_xfer;
      OP_UNIT_STAT:       delay = CNT_W'(UNIT_STAT_US);
      OP_SETUP:           delay = CNT_W'(SETUP_US);
      OP_INT_STAT:        delay = CNT_W'(INT_STAT_US);
      default:            delay = CNT_W'(MISC_US);
    endcase
  end

endmodule

// File: rtl/ct_countdown.sv
module ct_countdown #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             kill,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             busy,
  output logic             done
);

  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      remain_q <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else if (kill) begin
      remain_q <= '0;
      busy     <= 1'b0;
      done     <= 1'b0;
    end else if (load) begin
      remain_q <= load_val;
      busy     <= 1'b1;
      done     <= 1'b0;
    end else if (busy && tick) begin
      if (remain_q == CNT_W'(1)) begin
        remain_q <= '0;
        busy     <= 1'b0;
        done     <= 1'b1;
      end else begin
        remain_q <= remain_q - CNT_W'(1);
        done     <= 1'b0;
      end
    end else begin
      done <= 1'b0;
    end
  end

endmodule

// File: rtl/disk_cmd_timer.sv
module disk_cmd_timer
  import ct_pkg::*;
#(
  parameter int UNITS        = 4,
  parameter int CYL_W        = 16,
  parameter int CNT_W        = 24,
  parameter int SEEK_BASE_US = 700,
  parameter int STEP_US      = 100,
  parameter int HOME_US      = 6000,
  parameter int XFER_BASE_US = 8000,
  parameter int UNIT_STAT_US = 200,
  parameter int SETUP_US     = 1250,
  parameter int INT_STAT_US  = 142,
  parameter int MISC_US      = 140,
  localparam int UNIT_W      = (UNITS > 1) ? $clog2(UNITS) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  input  logic [3:0]        cmd_code,
  input  logic [UNIT_W-1:0] cmd_unit,
  input  logic [CYL_W-1:0]  cmd_cyl,
  input  logic              tick_us,
  input  logic              cancel,
  output logic              busy,
  output logic              done
);

  logic                   is_aux;
  logic                   start;
  logic                   kill;
  logic [CYL_W-1:0]       cur_cyl;
  logic [CNT_W-1:0]       delay;
  logic                   upd_we;
  logic [CYL_W-1:0]       upd_cyl;
  logic [UNITS*CYL_W-1:0] cyl_flat;

  assign is_aux = op_is_aux(cmd_code);
  assign start  = cmd_valid && !cancel && !is_aux;
  assign kill   = cancel || (cmd_valid && is_aux);

  ct_cyl_bank #(
    .UNITS (UNITS),
    .UNIT_W(UNIT_W),
    .CYL_W (CYL_W)
  ) u_bank (
    .clk  (clk),
    .rst  (rst),
    .we   (start && upd_we),
    .waddr(cmd_unit),
    .wdata(upd_cyl),
    .raddr(cmd_unit),
    .rdata(cur_cyl),
    .all_q(cyl_flat)
  );

  ct_delay_calc #(
    .CYL_W       (CYL_W),
    .CNT_W       (CNT_W),
    .SEEK_BASE_US(SEEK_BASE_US),
    .STEP_US     (STEP_US),
    .HOME_US     (HOME_US),
    .XFER_BASE_US(XFER_BASE_US),
    .UNIT_STAT_US(UNIT_STAT_US),
    .SETUP_US    (SETUP_US),
    .INT_STAT_US (INT_STAT_US),
    .MISC_US     (MISC_US)
  ) u_calc (
    .op     (cmd_code),
    .cur_cyl(cur_cyl),
    .tgt_cyl(cmd_cyl),
    .delay  (delay),
    .cyl_we (upd_we),
    .cyl_new(upd_cyl)
  );

  ct_countdown #(
    .CNT_W(CNT_W)
  ) u_count (
    .clk     (clk),
    .rst     (rst),
    .kill    (kill),
    .load    (start),
    .load_val(delay),
    .tick    (tick_us),
    .busy    (busy),
    .done    (done)
  );

endmodule

// File: rtl/disk_cmd_timer_chk.sv
module disk_cmd_timer_chk #(
  parameter int UNITS  = 4,
  parameter int UNIT_W = 2,
  parameter int CYL_W  = 16
) (
  input logic                   clk,
  input logic                   rst,
  input logic                   cmd_valid,
  input logic [3:0]             cmd_code,
  input logic [UNIT_W-1:0]      cmd_unit,
  input logic [CYL_W-1:0]       cmd_cyl,
  input logic                   cancel,
  input logic                   busy,
  input logic                   done,
  input logic [UNITS*CYL_W-1:0] cyl_flat
);

  logic issue;
  assign issue = cmd_valid && !cancel && (cmd_code != 4'hE) && (cmd_code != 4'hF);

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done) else $error("done longer than one cycle"); // R7

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy) else $error("busy while done"); // R7

  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(busy)) else $error("done without countdown"); // R7

  AST_CANCEL_QUIET: assert property (@(posedge clk) disable iff (rst)
    (cancel || (cmd_valid && (cmd_code == 4'hE || cmd_code == 4'hF))) |=> (!busy && !done))
    else $error("cancel did not stop countdown"); // R8

  AST_ISSUE_RESTARTS: assert property (@(posedge clk) disable iff (rst)
    issue |=> (busy && !done)) else $error("issued command not counting"); // R9

  AST_SEEK_STORES: assert property (@(posedge clk) disable iff (rst)
    (issue && cmd_code == 4'h1) |=>
      (cyl_flat[$past(cmd_unit)*CYL_W +: CYL_W] == $past(cmd_cyl)))
    else $error("seek target not stored"); // R2

  AST_HOME_ZERO: assert property (@(posedge clk) disable iff (rst)
    (issue && cmd_code == 4'h2) |=> (cyl_flat[$past(cmd_unit)*CYL_W +: CYL_W] == '0))
    else $error("home did not zero cylinder"); // R3

endmodule

bind disk_cmd_timer disk_cmd_timer_chk #(
  .UNITS (UNITS),
  .UNIT_W(UNIT_W),
  .CYL_W (CYL_W)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .cmd_valid(cmd_valid),
  .cmd_code (cmd_code),
  .cmd_unit (cmd_unit),
  .cmd_cyl  (cmd_cyl),
  .cancel   (cancel),
  .busy     (busy),
  .done     (done),
  .cyl_flat (cyl_flat)
);

// File: tb/disk_cmd_timer_bench.sv
`timescale 1ns/1ps
module disk_cmd_timer_bench;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [3:0]  cmd_code = 4'h0;
  logic [1:0]  cmd_unit = 2'd0;
  logic [15:0] cmd_cyl = 16'd0;
  logic        tick_us = 1'b0;
  logic        cancel = 1'b0;
  logic        busy;
  logic        done;

  int n_cmp = 0;
  int n_bad = 0;
  int cycles = 0;

  always #4 clk = ~clk;

  disk_cmd_timer u_disk_cmd_timer (
    .clk      (clk),
    .rst      (rst),
    .cmd_valid(cmd_valid),
    .cmd_code (cmd_code),
    .cmd_unit (cmd_unit),
    .cmd_cyl  (cmd_cyl),
    .tick_us  (tick_us),
    .cancel   (cancel),
    .busy     (busy),
    .done     (done)
  );

  typedef struct packed {
    logic [3:0]  code;
    logic [1:0]  unit;
    logic [15:0] cyl;
    logic [31:0] ticks;
  } vec_t;

  localparam int NVEC = 15;
  localparam vec_t VECS [NVEC] = '{
    '{4'h1, 2'd0, 16'd10, 32'd1700},  // R2 seek u0 0->10
    '{4'h1, 2'd1, 16'd3,  32'd1000},  // R2 R10 seek u1 0->3
    '{4'h3, 2'd0, 16'd10, 32'd8100},  // R4 read, zero distance charged 1
    '{4'h4, 2'd0, 16'd12, 32'd8200},  // R4 write, distance 2
    '{4'h1, 2'd0, 16'd4,  32'd1300},  // R4 write left u0 at 10, seek 10->4
    '{4'h2, 2'd0, 16'd77, 32'd6000},  // R3 home
    '{4'h1, 2'd0, 16'd0,  32'd700},   // R3 home left u0 at 0
    '{4'h3, 2'd1, 16'd0,  32'd8300},  // R10 u1 still at 3
    '{4'h5, 2'd2, 16'd0,  32'd200},   // R5 unit status
    '{4'h6, 2'd2, 16'd0,  32'd1250},  // R5 setup
    '{4'h7, 2'd2, 16'd0,  32'd142},   // R5 interrupt status
    '{4'h0, 2'd2, 16'd0,  32'd140},   // R6 misc 0
    '{4'hB, 2'd2, 16'd99, 32'd140},   // R6 misc B
    '{4'h1, 2'd3, 16'd20, 32'd2700},  // R10 u3 fresh from 0
    '{4'h1, 2'd1, 16'd1,  32'd900}    // R10 u1 3->1
  };

  always @(posedge clk) begin
    cycles++;
    if (cycles > 190000) begin
      n_bad++;
      $display("FAIL R7 watchdog expired: actual=%0d cycles expected<190000", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [3:0] code, input logic [1:0] unit, input logic [15:0] cyl);
    @(negedge clk);
    tick_us   = 1'b0;
    cmd_valid = 1'b1;
    cmd_code  = code;
    cmd_unit  = unit;
    cmd_cyl   = cyl;
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  // Issue a command and count ticks until done; tick every 'period' cycles.
  task automatic measure(input logic [3:0] code, input logic [1:0] unit, input logic [15:0] cyl,
                         input int exp, input int period, input string tag);
    int  ticks = 0;
    int  cyc = 0;
    bit  seen = 0;
    bit  busy_ok = 1;
    int  limit = exp * period + 50;
    issue(code, unit, cyl);
    while (!seen && cyc < limit) begin
      if (done) begin
        seen = 1;
        check(busy == 1'b0, {tag, " busy low with done"}, busy, 0);
      end else begin
        if (!busy) busy_ok = 0;
        tick_us = (period == 1) || ((cyc % period) == period - 1);
        if (tick_us) ticks++;
        cyc++;
        @(negedge clk);
      end
    end
    tick_us = 1'b0;
    check(seen, {tag, " done seen"}, seen, 1);
    check(ticks == exp, {tag, " delay ticks"}, ticks, exp);
    check(busy_ok, {tag, " busy held"}, busy_ok, 1);
  endtask

  // Run n cycles with ticks, counting done pulses.
  task automatic quiet(input int n, input string tag);
    int pulses = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_us = 1'b1;
      if (done) pulses++;
    end
    tick_us = 1'b0;
    check(pulses == 0, {tag, " no done"}, pulses, 0);
    check(busy == 1'b0, {tag, " busy low"}, busy, 0);
  endtask

  task automatic run_ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      tick_us = 1'b1;
    end
    @(negedge clk);
    tick_us = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(busy == 1'b0, "R1 reset busy", busy, 0);
    check(done == 1'b0, "R1 reset done", done, 0);
    quiet(20, "R7 idle ticks");

    for (int v = 0; v < NVEC; v++) begin
      measure(VECS[v].code, VECS[v].unit, VECS[v].cyl, int'(VECS[v].ticks), 1,
              $sformatf("R2-vector %0d", v));
    end

    // R7: sparse ticks, delay counted in ticks not cycles
    measure(4'h7, 2'd0, 16'd0, 142, 4, "R7 sparse tick");

    // R8: cancel input
    issue(4'h6, 2'd0, 16'd0);
    run_ticks(300);
    @(negedge clk); cancel = 1'b1;
    @(negedge clk); cancel = 1'b0;
    quiet(1500, "R8 cancel input");

    // R8: auxiliary clear codes
    issue(4'h6, 2'd0, 16'd0);
    run_ticks(300);
    issue(4'hE, 2'd0, 16'd0);
    quiet(1500, "R8 aux E");
    issue(4'h5, 2'd0, 16'd0);
    run_ticks(50);
    issue(4'hF, 2'd0, 16'd0);
    quiet(400, "R8 aux F");

    // R8: cancel beats a simultaneous seek, which is discarded
    @(negedge clk);
    cmd_valid = 1'b1; cmd_code = 4'h1; cmd_unit = 2'd2; cmd_cyl = 16'd40; cancel = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0; cancel = 1'b0;
    quiet(900, "R8 cancel priority");
    measure(4'h1, 2'd2, 16'd0, 700, 1, "R8 discarded seek left u2 at 0");

    // R9: reload while busy
    issue(4'h6, 2'd1, 16'd0);
    run_ticks(500);
    measure(4'h7, 2'd1, 16'd0, 142, 1, "R9 reload");
    quiet(1300, "R9 single completion");

    // R1: reset clears cylinders and a pending countdown
    measure(4'h1, 2'd0, 16'd30, 3700, 1, "R2 seek u0 0->30");
    issue(4'h6, 2'd0, 16'd0);
    run_ticks(100);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    check(busy == 1'b0, "R1 reset mid-count busy", busy, 0);
    quiet(1300, "R1 reset mid-count");
    measure(4'h1, 2'd0, 16'd0, 700, 1, "R1 cylinder cleared");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule